// File: doc/BRIEF.md
# Transfer-Sized Byte Queue Pair

This block holds two byte queues between a register interface and a serial bus engine. One queue carries outgoing bytes: software pushes them and the bus engine pulls them. The other carries incoming bytes: the bus engine pushes what it captured and software pulls them. Software programs a transfer length before a transaction. The full and empty flags follow that programmed byte count, not the physical storage depth. Full therefore tells the bus engine that a whole transaction is loaded, and empty tells it that the transaction has drained. No interrupt is needed to start or end a transfer.

Each queue runs its own small flag state machine with three states. In Q_IDLE no byte of the current transaction has been accepted and empty is high. The first accepted push latches the programmed length and leads to Q_FILL, or straight to Q_LOADED when the length is one. Q_FILL moves to Q_LOADED on the push that brings the pushed count up to the latched length. Q_LOADED holds full high and returns to Q_IDLE on the pop that brings the popped count up to the latched length. Pops are also accepted in Q_FILL whenever at least one byte is stored. A soft reset returns either machine to Q_IDLE and clears both pointers in one clock.

The read side is first-word fall-through: the oldest byte is always on the pop data port, and a pop moves past it at the clock edge. Both 8-bit storage pointers of each queue are outputs, so the register side can show them.

Top module: `xfer_fifo_pair`

## Requirements
- R1: After rst_n is deasserted, or one clock after soft_rst is sampled high, every pointer reads 0, both empty flags read 1, and both full flags read 0 while xfer_size is non-zero. Stored bytes are discarded.
- R2: Full goes high in the cycle after the accepted push that makes the pushed count equal to the latched transfer length.
- R3: A push while full is refused. The write pointer does not move and the byte is never popped.
- R4: A pop while nothing is stored (for example while empty) is refused and the read pointer does not move.
- R5: Empty goes high, and full low, in the cycle after the pop that makes the popped count equal to the latched length. The queue then starts a new transaction.
- R6: Bytes come out in push order, and the oldest stored byte is on the pop data port before the pop edge.
- R7: The length is latched at the first accepted push of a transaction. A change of xfer_size after that point does not move the full point of that transaction.
- R8: While idle with xfer_size equal to 0, full and empty are both 1 and every push is refused.
- R9: The receive queue follows the same rules as the transmit queue, and activity on one queue leaves the other's flags and pointers untouched.
- R10: Each pointer advances by exactly one per accepted operation and wraps modulo 256.
- R11: A push and a pop in the same cycle are both accepted when each alone would be.
- R12: Empty drops in the cycle after the first accepted push of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of both queues |
| xfer_size | input | 8 | Programmed transaction length in bytes |
| tx_push | input | 1 | Software write enable, transmit queue |
| tx_push_data | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Bus engine read enable, transmit queue |
| tx_pop_data | output | 8 | Oldest byte of transmit queue |
| tx_full | output | 1 | Transmit transaction loaded |
| tx_empty | output | 1 | Transmit transaction drained or not begun |
| tx_wr_ptr | output | 8 | Transmit write pointer |
| tx_rd_ptr | output | 8 | Transmit read pointer |
| rx_push | input | 1 | Bus engine write enable, receive queue |
| rx_push_data | input | 8 | Byte captured from the bus |
| rx_pop | input | 1 | Software read enable, receive queue |
| rx_pop_data | output | 8 | Oldest byte of receive queue |
| rx_full | output | 1 | Receive transaction complete |
| rx_empty | output | 1 | Receive transaction drained or not begun |
| rx_wr_ptr | output | 8 | Receive write pointer |
| rx_rd_ptr | output | 8 | Receive read pointer |

## Verification
The transmit queue is first filled to exactly the programmed length and then pushed once more. This separates a flag based on the byte count from one based on physical depth, and shows that the surplus byte is dropped. A change of length in the middle of a transaction checks that the length is latched rather than followed live. An interleaved pattern with a same-cycle push and pop checks that both operations are accepted together and that ordering is kept. Two 200-byte transactions push the pointers past 255 to expose wrap faults, a zero length checks that both flags stay high, and traffic on the receive queue alone shows that the two queues are independent.

// File: rtl/xfp_pkg.sv
package xfp_pkg;
    typedef enum logic [1:0] {
        Q_IDLE   = 2'd0,
        Q_FILL   = 2'd1,
        Q_LOADED = 2'd2
    } qstate_e;
endpackage

// File: rtl/xfp_store.sv
module xfp_store #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              push_ok,
    input  logic              pop_ok,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] pop_data,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  rd_ptr
);
    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (soft_rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(1);
        end
    end

    assign pop_data = mem[rd_ptr];
endmodule

// File: rtl/xfp_flag_fsm.sv
module xfp_flag_fsm
    import xfp_pkg::*;
#(
    parameter int SIZE_W = 8,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [SIZE_W-1:0] size,
    input  logic              push_req,
    input  logic              pop_req,
    output logic              push_ok,
    output logic              pop_ok,
    output logic              full,
    output logic              empty
);
    localparam int DEPTH = 1 << PTR_W;

    qstate_e           state, state_nxt;
    logic [SIZE_W-1:0] lat_size;
    logic [SIZE_W-1:0] wr_cnt;
    logic [SIZE_W-1:0] rd_cnt;
    logic [SIZE_W-1:0] cur_size;
    logic [SIZE_W-1:0] occ;
    logic              room;
    logic              wr_last;
    logic              rd_last;

    // Flag and acceptance outputs
    always_comb begin
        cur_size = (state == Q_IDLE) ? size : lat_size;
        occ      = wr_cnt - rd_cnt;
        room     = int'(occ) < DEPTH;
        full     = (state == Q_LOADED) || ((state == Q_IDLE) && (size == '0));
        empty    = (state == Q_IDLE);
        push_ok  = push_req && !full && room;
        pop_ok   = pop_req && (occ != '0);
        wr_last  = (wr_cnt + SIZE_W'(1)) == cur_size;
        rd_last  = (rd_cnt + SIZE_W'(1)) == lat_size;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            Q_IDLE: begin
                if (push_ok) state_nxt = wr_last ? Q_LOADED : Q_FILL;
            end
            Q_FILL: begin
                if (push_ok && wr_last) state_nxt = Q_LOADED;
            end
            Q_LOADED: begin
                if (pop_ok && rd_last) state_nxt = Q_IDLE;
            end
            default: state_nxt = Q_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= Q_IDLE;
        else if (soft_rst) state <= Q_IDLE;
        else               state <= state_nxt;
    end

    // Transaction counters and latched length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt   <= '0;
            rd_cnt   <= '0;
            lat_size <= '0;
        end else if (soft_rst) begin
            wr_cnt   <= '0;
            rd_cnt   <= '0;
            lat_size <= '0;
        end else begin
            if ((state == Q_IDLE) && push_ok) lat_size <= size;
            if ((state == Q_LOADED) && (state_nxt == Q_IDLE)) begin
                wr_cnt <= '0;
                rd_cnt <= '0;
            end else begin
                if (push_ok) wr_cnt <= wr_cnt + SIZE_W'(1);
                if (pop_ok)  rd_cnt <= rd_cnt + SIZE_W'(1);
            end
        end
    end

    AST_BOTH_FLAGS_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (full && empty) |-> (size == '0)) else $error("full and empty with nonzero length"); // R8

    AST_LOADED_HOLDS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && full && !empty && $stable(full)) |-> $stable(lat_size)) else $error("latched length moved"); // R7
endmodule

// File: rtl/xfp_queue.sv
module xfp_queue #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 8,
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [SIZE_W-1:0] size,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic              full,
    output logic              empty,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  rd_ptr
);
    logic push_ok;
    logic pop_ok;

    xfp_flag_fsm #(.SIZE_W(SIZE_W), .PTR_W(PTR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .size     (size),
        .push_req (push_req),
        .pop_req  (pop_req),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .full     (full),
        .empty    (empty)
    );

    xfp_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .push_data (push_data),
        .pop_data  (pop_data),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr)
    );

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !soft_rst) |=> $stable(wr_ptr)) else $error("push accepted while full"); // R3

    AST_NO_READ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !soft_rst) |=> $stable(rd_ptr)) else $error("pop accepted while empty"); // R4

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (wr_ptr == '0 && rd_ptr == '0 && empty)) else $error("soft reset incomplete"); // R1

    AST_EMPTY_PTRS_MEET: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (wr_ptr == rd_ptr)) else $error("empty with stored bytes"); // R5
endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 8,
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [SIZE_W-1:0] xfer_size,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_push_data,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_pop_data,
    output logic              tx_full,
    output logic              tx_empty,
    output logic [PTR_W-1:0]  tx_wr_ptr,
    output logic [PTR_W-1:0]  tx_rd_ptr,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_pop_data,
    output logic              rx_full,
    output logic              rx_empty,
    output logic [PTR_W-1:0]  rx_wr_ptr,
    output logic [PTR_W-1:0]  rx_rd_ptr
);
    // Outgoing bytes: software in, bus engine out
    xfp_queue #(.DATA_W(DATA_W), .PTR_W(PTR_W), .SIZE_W(SIZE_W)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .size      (xfer_size),
        .push_req  (tx_push),
        .push_data (tx_push_data),
        .pop_req   (tx_pop),
        .pop_data  (tx_pop_data),
        .full      (tx_full),
        .empty     (tx_empty),
        .wr_ptr    (tx_wr_ptr),
        .rd_ptr    (tx_rd_ptr)
    );

    // Incoming bytes: bus engine in, software out
    xfp_queue #(.DATA_W(DATA_W), .PTR_W(PTR_W), .SIZE_W(SIZE_W)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .size      (xfer_size),
        .push_req  (rx_push),
        .push_data (rx_push_data),
        .pop_req   (rx_pop),
        .pop_data  (rx_pop_data),
        .full      (rx_full),
        .empty     (rx_empty),
        .wr_ptr    (rx_wr_ptr),
        .rd_ptr    (rx_rd_ptr)
    );

    AST_QUEUES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_push && !rx_pop && !soft_rst) |=> ($stable(rx_wr_ptr) && $stable(rx_rd_ptr))) else $error("receive queue moved without request"); // R9
endmodule

// File: tb/xfer_fifo_pair_tb.sv
`timescale 1ns/1ps
module xfer_fifo_pair_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic [7:0] xfer_size = 8'd4;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_push_data = '0, rx_push_data = '0;
    logic [7:0] tx_pop_data, rx_pop_data, tx_wr_ptr, tx_rd_ptr, rx_wr_ptr, rx_rd_ptr;
    logic       tx_full, tx_empty, rx_full, rx_empty;

    int tests = 0;
    int fails = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #2 clk = ~clk;

    xfer_fifo_pair u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .xfer_size(xfer_size),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_full(tx_full), .tx_empty(tx_empty),
        .tx_wr_ptr(tx_wr_ptr), .tx_rd_ptr(tx_rd_ptr),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .rx_full(rx_full), .rx_empty(rx_empty),
        .rx_wr_ptr(rx_wr_ptr), .rx_rd_ptr(rx_rd_ptr)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: one operation per call; accepted pushes feed the scoreboard,
    // accepted pops are compared against it before the pop edge.
    task automatic op(input bit rx, input bit dp, input logic [7:0] d, input bit dq,
                      input bit acc_push, input bit acc_pop, input string req);
        @(negedge clk);
        if (rx) begin rx_push = dp; rx_push_data = d; rx_pop = dq; end
        else    begin tx_push = dp; tx_push_data = d; tx_pop = dq; end
        if (dq && acc_pop) begin
            if (rx) chk(req, rx_pop_data, (rxq.size() > 0) ? int'(rxq.pop_front()) : -1);
            else    chk(req, tx_pop_data, (txq.size() > 0) ? int'(txq.pop_front()) : -1);
        end
        if (dp && acc_push) begin
            if (rx) rxq.push_back(d); else txq.push_back(d);
        end
        @(negedge clk);
        tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
    endtask

    task automatic push(input bit rx, input logic [7:0] d, input bit acc, input string req);
        op(rx, 1'b1, d, 1'b0, acc, 1'b0, req);
    endtask

    task automatic pop(input bit rx, input bit acc, input string req);
        op(rx, 1'b0, 8'h00, 1'b1, 1'b0, acc, req);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_empty", tx_empty, 1); chk("R1 tx_full", tx_full, 0);
        chk("R1 tx_wr_ptr", tx_wr_ptr, 0); chk("R1 tx_rd_ptr", tx_rd_ptr, 0);
        chk("R1 rx_empty", rx_empty, 1); chk("R1 rx_full", rx_full, 0);

        // R2 / R12 fill to length 4
        push(0, 8'hA0, 1, "R12");
        chk("R12 tx_empty drops", tx_empty, 0); chk("R2 not full yet", tx_full, 0);
        push(0, 8'hA1, 1, "R2"); push(0, 8'hA2, 1, "R2");
        chk("R2 full before last", tx_full, 0);
        push(0, 8'hA3, 1, "R2");
        chk("R2 full at length", tx_full, 1);
        chk("R10 wr_ptr after 4", tx_wr_ptr, 4);
        // R3 push while full
        push(0, 8'hEE, 0, "R3");
        chk("R3 wr_ptr held", tx_wr_ptr, 4); chk("R3 still full", tx_full, 1);

        // R6 / R5 drain
        pop(0, 1, "R6"); pop(0, 1, "R6"); pop(0, 1, "R6");
        chk("R5 not empty before last", tx_empty, 0);
        pop(0, 1, "R6");
        chk("R5 empty after last", tx_empty, 1); chk("R5 full cleared", tx_full, 0);
        chk("R10 rd_ptr after 4", tx_rd_ptr, 4);
        // R4 pop while empty
        pop(0, 0, "R4");
        chk("R4 rd_ptr held", tx_rd_ptr, 4);

        // R7 length latched at first push
        xfer_size = 8'd3;
        push(0, 8'hB0, 1, "R7");
        xfer_size = 8'd6;
        push(0, 8'hB1, 1, "R7");
        chk("R7 not full at 2", tx_full, 0);
        push(0, 8'hB2, 1, "R7");
        chk("R7 full at latched 3", tx_full, 1);
        chk("R7 wr_ptr", tx_wr_ptr, 7);
        pop(0, 1, "R7"); pop(0, 1, "R7"); pop(0, 1, "R7");
        chk("R7 empty after 3", tx_empty, 1);

        // R11 simultaneous push and pop
        xfer_size = 8'd5;
        push(0, 8'hC0, 1, "R11"); push(0, 8'hC1, 1, "R11");
        op(0, 1'b1, 8'hC2, 1'b1, 1'b1, 1'b1, "R11 same-cycle pop data");
        chk("R11 wr_ptr", tx_wr_ptr, 10); chk("R11 rd_ptr", tx_rd_ptr, 8);
        push(0, 8'hC3, 1, "R11"); push(0, 8'hC4, 1, "R11");
        chk("R11 full at 5 pushed", tx_full, 1);
        for (int i = 0; i < 4; i++) pop(0, 1, "R11");
        chk("R11 empty after 5 popped", tx_empty, 1);

        // R8 zero length
        xfer_size = 8'd0;
        @(negedge clk);
        chk("R8 full", tx_full, 1); chk("R8 empty", tx_empty, 1);
        push(0, 8'hD0, 0, "R8");
        chk("R8 wr_ptr held", tx_wr_ptr, 12);

        // R9 receive queue, independent of transmit
        xfer_size = 8'd3;
        push(1, 8'hE0, 1, "R9"); push(1, 8'hE1, 1, "R9"); push(1, 8'hE2, 1, "R9");
        chk("R9 rx_full", rx_full, 1); chk("R9 rx_wr_ptr", rx_wr_ptr, 3);
        chk("R9 tx_empty untouched", tx_empty, 1); chk("R9 tx_wr_ptr untouched", tx_wr_ptr, 12);
        pop(1, 1, "R9"); pop(1, 1, "R9"); pop(1, 1, "R9");
        chk("R9 rx_empty", rx_empty, 1); chk("R9 tx_rd_ptr untouched", tx_rd_ptr, 12);

        // R10 pointer wrap over two 200-byte transactions
        xfer_size = 8'd200;
        for (int t = 0; t < 2; t++) begin
            for (int i = 0; i < 200; i++) push(0, 8'(i * 7 + t), 1, "R10");
            chk("R10 full at 200", tx_full, 1);
            for (int i = 0; i < 200; i++) pop(0, 1, "R10 data");
        end
        chk("R10 wr_ptr wrapped", tx_wr_ptr, 156); chk("R10 rd_ptr wrapped", tx_rd_ptr, 156);

        // R1 soft reset
        xfer_size = 8'd4;
        push(0, 8'hF0, 1, "R1"); push(0, 8'hF1, 1, "R1"); push(1, 8'hF2, 1, "R1");
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        txq.delete(); rxq.delete();
        chk("R1 soft tx_wr_ptr", tx_wr_ptr, 0); chk("R1 soft tx_rd_ptr", tx_rd_ptr, 0);
        chk("R1 soft tx_empty", tx_empty, 1); chk("R1 soft tx_full", tx_full, 0);
        chk("R1 soft rx_wr_ptr", rx_wr_ptr, 0); chk("R1 soft rx_empty", rx_empty, 1);
        pop(0, 0, "R1");
        chk("R1 old bytes discarded", tx_rd_ptr, 0);
        push(0, 8'h5A, 1, "R1"); pop(0, 1, "R1 after soft reset");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule